// File: doc/BRIEF.md
# Sector Sequencer with Half-Sector Handshake

This block drives the cell address for a sector-organised sample store. Record, play and fast-forward (skip) operations advance the address by one cell on each sample tick. Each sector holds `CELLS_PER_SECTOR` cells, and there are `NUM_SECTORS` sectors. A looping variant of each operation stays inside one sector. A chained variant moves on to the next sector each time a sector ends.

Halfway through a sector, the block pulls the half-sector line low. This tells the host that the next command can be staged. A command that arrives while the line is low is held in a one-entry slot and takes effect exactly at the sector boundary, so the stream has no gap. A command that arrives while the line is high takes effect at once.

The command port has a valid strobe and no ready. Every command is taken in the cycle it is presented, so the port never applies back-pressure. When a second command arrives before the boundary, it overwrites the one already held.

The block also does the following:
- It reports an end-of-data cell found during play or skip.
- It reports a run past the last sector.
- It issues an end-of-data marker write when a recording is halted.
- It has a sleep state that only a wake command leaves.

Top module: `sector_sequencer`

## Requirements
- R1: After reset, `active_n`, `half_sec_n` and `irq_n` are 1. `cell_wr_en`, `cell_rd_en`, `mute`, `pwr_down`, `eod_mark_wr`, `ovf_set` and `eod_set` are 0.
- R2: Commands are applied only when `cmd_valid` is 1. The codes are:
  - 0 none
  - 1 looping record, 2 chained record
  - 3 looping play, 4 chained play
  - 5 looping skip, 6 chained skip
  - 7 halt, 8 halt-and-sleep, 9 wake

  While an operation runs, each `sample_tick` produces one access at `cell_addr = sector*CELLS_PER_SECTOR + cell`, and the cell index then advances by one. Record raises `cell_wr_en`. Play and skip raise `cell_rd_en`. In a cycle where a command takes effect at once, the tick is dropped.
- R3: `half_sec_n` is low exactly while an operation runs with a cell index of at least `CELLS_PER_SECTOR/2`. It is high again at cell 0 of the next sector.
- R4: A looping command starts at cell 0 of `cmd_sector`. If nothing is pending when the sector ends, it restarts at cell 0 of the same sector.
- R5: A chained command given at once restarts cell 0 of the current sector. At each boundary with nothing pending, a chained operation moves to the next sector. A chained command taken from the slot at a boundary also moves to the next sector.
- R6: A command arriving while `half_sec_n` is low is held, with the newest one winning, and is applied at the end of the sector. A command arriving while the block is idle, or while `half_sec_n` is high, is applied at the next clock edge.
- R7: If a play or skip read sees `eod_bit_in` = 1, the operation stops. In the following cycle, `eod_set` is 1 and `irq_n` is 0, each for one cycle.
- R8: Halting a recording that has written at least one cell pulses `eod_mark_wr` for one cycle, with `eod_mark_addr` equal to the last written cell. If no cell was written, there is no pulse.
- R9: A chained step beyond sector `NUM_SECTORS-1` stops the operation. In the following cycle, `ovf_set` is 1 and `irq_n` is 0, each for one cycle.
- R10: `active_n` is 0 while record, play or skip runs. `mute` is 1 exactly while skip runs.
- R11: Code 8 halts and sets `pwr_down`. While `pwr_down` is 1, every code except 9 is ignored. Code 9 clears `pwr_down`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe (always accepted) |
| cmd_code | input | 4 | Command code, see R2 |
| cmd_sector | input | SECT_W | Sector for looping commands |
| sample_tick | input | 1 | One-cycle sample strobe |
| eod_bit_in | input | 1 | End-of-data bit of the cell being read |
| cell_addr | output | ADDR_W | Current cell address |
| cell_wr_en | output | 1 | Write strobe for the current cell |
| cell_rd_en | output | 1 | Read strobe for the current cell |
| half_sec_n | output | 1 | Low during the second half of an active sector |
| active_n | output | 1 | Low while an operation runs |
| irq_n | output | 1 | One-cycle low pulse on end-of-data or overflow |
| mute | output | 1 | High during skip |
| pwr_down | output | 1 | Sleep state |
| eod_mark_wr | output | 1 | End-of-data marker write strobe |
| eod_mark_addr | output | ADDR_W | Cell address for the marker |
| ovf_set | output | 1 | Overflow flag set pulse |
| eod_set | output | 1 | End-of-data flag set pulse |

## Verification
The embedded properties check a set of rules on every cycle:
- the half-sector line is never low while idle;
- reads and writes never coincide, and no write happens while muted;
- accesses stay inside the array;
- every event pulse (marker, overflow, end-of-data) and the sleep state coincide with an idle sequencer;
- overflow and end-of-data are never reported together.

Some behaviour only the bench scenarios can show:
- which sector a boundary moves to;
- the way the newest held command replaces an older one;
- whether a halt's marker points at the true last written cell;
- whether commands are dropped while asleep.

The bench compares a behavioural reference against every output on every clock.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  typedef enum logic [3:0] {
    CMD_NONE       = 4'd0,
    CMD_REC_LOOP   = 4'd1,
    CMD_REC_NEXT   = 4'd2,
    CMD_PLAY_LOOP  = 4'd3,
    CMD_PLAY_NEXT  = 4'd4,
    CMD_SKIP_LOOP  = 4'd5,
    CMD_SKIP_NEXT  = 4'd6,
    CMD_HALT       = 4'd7,
    CMD_HALT_SLEEP = 4'd8,
    CMD_WAKE       = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_REC  = 2'd1,
    OP_PLAY = 2'd2,
    OP_SKIP = 2'd3
  } op_e;

  function automatic op_e op_of(input logic [3:0] code);
    case (code)
      4'd1, 4'd2: op_of = OP_REC;
      4'd3, 4'd4: op_of = OP_PLAY;
      4'd5, 4'd6: op_of = OP_SKIP;
      default:    op_of = OP_IDLE;
    endcase
  endfunction

  function automatic logic is_loop(input logic [3:0] code);
    is_loop = code[0];
  endfunction

endpackage

// File: rtl/sseq_pending.sv
module sseq_pending #(
  parameter int SECT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              clr,
  input  logic [3:0]        code_in,
  input  logic [SECT_W-1:0] sec_in,
  output logic              valid_o,
  output logic [3:0]        code_o,
  output logic [SECT_W-1:0] sec_o
);

  logic              v_q;
  logic [3:0]        code_q;
  logic [SECT_W-1:0] sec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      code_q <= '0;
      sec_q  <= '0;
    end else if (clr) begin
      v_q <= 1'b0;
    end else if (ld) begin
      v_q    <= 1'b1;
      code_q <= code_in;
      sec_q  <= sec_in;
    end
  end

  // a command arriving in the boundary cycle supersedes the held one
  assign valid_o = ld | v_q;
  assign code_o  = ld ? code_in : code_q;
  assign sec_o   = ld ? sec_in  : sec_q;

endmodule

// File: rtl/sseq_events.sv
module sseq_events #(
  parameter int ADDR_W = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mark_ev,
  input  logic ovf_ev,
  input  logic eod_ev,
  output logic eod_mark_wr,
  output logic ovf_set,
  output logic eod_set,
  output logic irq_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eod_mark_wr <= 1'b0;
      ovf_set     <= 1'b0;
      eod_set     <= 1'b0;
      irq_n       <= 1'b1;
    end else begin
      eod_mark_wr <= mark_ev;
      ovf_set     <= ovf_ev;
      eod_set     <= eod_ev;
      irq_n       <= !(ovf_ev || eod_ev);
    end
  end

  // R9
  ovf_eod_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_set && eod_set));

endmodule

// File: rtl/sector_sequencer.sv
module sector_sequencer
  import sseq_pkg::*;
#(
  parameter  int NUM_SECTORS      = 1280,
  parameter  int CELLS_PER_SECTOR = 3000,
  localparam int SECT_W = $clog2(NUM_SECTORS),
  localparam int CELL_W = $clog2(CELLS_PER_SECTOR),
  localparam int ADDR_W = $clog2(NUM_SECTORS * CELLS_PER_SECTOR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_code,
  input  logic [SECT_W-1:0] cmd_sector,
  input  logic              sample_tick,
  input  logic              eod_bit_in,
  output logic [ADDR_W-1:0] cell_addr,
  output logic              cell_wr_en,
  output logic              cell_rd_en,
  output logic              half_sec_n,
  output logic              active_n,
  output logic              irq_n,
  output logic              mute,
  output logic              pwr_down,
  output logic              eod_mark_wr,
  output logic [ADDR_W-1:0] eod_mark_addr,
  output logic              ovf_set,
  output logic              eod_set
);

  localparam int HALF       = CELLS_PER_SECTOR / 2;
  localparam int TOTAL      = NUM_SECTORS * CELLS_PER_SECTOR;
  localparam logic [SECT_W-1:0] LAST_SEC = SECT_W'(NUM_SECTORS - 1);
  localparam logic [CELL_W-1:0] LAST_CEL = CELL_W'(CELLS_PER_SECTOR - 1);

  op_e               mode_q, mode_d;
  logic              loop_q, loop_d;
  logic [SECT_W-1:0] sec_q, sec_d;
  logic [CELL_W-1:0] cel_q, cel_d;
  logic              pdn_q, pdn_d;
  logic              any_q, any_d;
  logic [ADDR_W-1:0] last_q, last_d;

  logic running, second_half, at_end;
  logic eff_cmd, imm, queue_ld, tick_go, eod_hit;
  logic mark_ev, ovf_ev, eod_ev;
  logic              pend_v;
  logic [3:0]        pend_code;
  logic [SECT_W-1:0] pend_sec;

  assign running     = (mode_q != OP_IDLE);
  assign second_half = (cel_q >= CELL_W'(HALF));
  assign at_end      = (cel_q == LAST_CEL);

  assign eff_cmd  = cmd_valid && (pdn_q ? (cmd_code == CMD_WAKE)
                                        : (cmd_code != CMD_NONE && cmd_code <= 4'd8));
  assign imm      = eff_cmd && (!running || !second_half);
  assign queue_ld = eff_cmd && running && second_half;
  assign tick_go  = running && sample_tick && !imm;

  assign cell_addr  = ADDR_W'(sec_q) * ADDR_W'(CELLS_PER_SECTOR) + ADDR_W'(cel_q);
  assign cell_wr_en = tick_go && (mode_q == OP_REC);
  assign cell_rd_en = tick_go && (mode_q == OP_PLAY || mode_q == OP_SKIP);
  assign eod_hit    = cell_rd_en && eod_bit_in;

  assign half_sec_n    = !(running && second_half);
  assign active_n      = !running;
  assign mute          = (mode_q == OP_SKIP);
  assign pwr_down      = pdn_q;
  assign eod_mark_addr = last_q;

  sseq_pending #(.SECT_W(SECT_W)) u_pending (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (queue_ld),
    .clr     (imm || (tick_go && (at_end || eod_hit))),
    .code_in (cmd_code),
    .sec_in  (cmd_sector),
    .valid_o (pend_v),
    .code_o  (pend_code),
    .sec_o   (pend_sec)
  );

  sseq_events #(.ADDR_W(ADDR_W)) u_events (
    .clk         (clk),
    .rst_n       (rst_n),
    .mark_ev     (mark_ev),
    .ovf_ev      (ovf_ev),
    .eod_ev      (eod_ev),
    .eod_mark_wr (eod_mark_wr),
    .ovf_set     (ovf_set),
    .eod_set     (eod_set),
    .irq_n       (irq_n)
  );

  always_comb begin
    mode_d  = mode_q;
    loop_d  = loop_q;
    sec_d   = sec_q;
    cel_d   = cel_q;
    pdn_d   = pdn_q;
    any_d   = any_q;
    last_d  = last_q;
    mark_ev = 1'b0;
    ovf_ev  = 1'b0;
    eod_ev  = 1'b0;
    if (imm) begin
      case (cmd_code)
        CMD_WAKE: pdn_d = 1'b0;
        CMD_HALT, CMD_HALT_SLEEP: begin
          mark_ev = (mode_q == OP_REC) && any_q;
          mode_d  = OP_IDLE;
          pdn_d   = (cmd_code == CMD_HALT_SLEEP);
        end
        default: begin
          mode_d = op_of(cmd_code);
          loop_d = is_loop(cmd_code);
          cel_d  = '0;
          any_d  = 1'b0;
          if (is_loop(cmd_code)) sec_d = cmd_sector;
        end
      endcase
    end else if (tick_go) begin
      if (cell_wr_en) begin
        last_d = cell_addr;
        any_d  = 1'b1;
      end
      if (eod_hit) begin
        mode_d = OP_IDLE;
        eod_ev = 1'b1;
      end else if (at_end) begin
        cel_d = '0;
        if (pend_v && (pend_code == CMD_HALT || pend_code == CMD_HALT_SLEEP)) begin
          mark_ev = (mode_q == OP_REC);
          mode_d  = OP_IDLE;
          pdn_d   = (pend_code == CMD_HALT_SLEEP);
        end else begin
          if (pend_v) begin
            mode_d = op_of(pend_code);
            loop_d = is_loop(pend_code);
            any_d  = any_d && (op_of(pend_code) == OP_REC);
          end
          if (pend_v && is_loop(pend_code)) begin
            sec_d = pend_sec;
          end else if (pend_v || !loop_q) begin
            if (sec_q == LAST_SEC) begin
              mode_d = OP_IDLE;
              ovf_ev = 1'b1;
            end else begin
              sec_d = sec_q + SECT_W'(1);
            end
          end
        end
      end else begin
        cel_d = cel_q + CELL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= OP_IDLE;
      loop_q <= 1'b0;
      sec_q  <= '0;
      cel_q  <= '0;
      pdn_q  <= 1'b0;
      any_q  <= 1'b0;
      last_q <= '0;
    end else begin
      mode_q <= mode_d;
      loop_q <= loop_d;
      sec_q  <= sec_d;
      cel_q  <= cel_d;
      pdn_q  <= pdn_d;
      any_q  <= any_d;
      last_q <= last_d;
    end
  end

  // R3
  half_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half_sec_n |-> !active_n);

  // R2
  access_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cell_wr_en && cell_rd_en));

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_wr_en || cell_rd_en) |-> (int'(cell_addr) < TOTAL));

  // R10
  write_unmuted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_wr_en |-> !mute);

  // R7
  eod_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eod_set |-> (active_n && !irq_n));

  // R9
  ovf_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |-> (active_n && !irq_n));

  // R8
  mark_on_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eod_mark_wr |-> active_n);

  // R11
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> active_n);

endmodule

// File: tb/tb_sector_sequencer.sv
`timescale 1ns/100ps
module tb_sector_sequencer;

  localparam int NS = 4;
  localparam int NC = 8;
  localparam int HF = NC / 2;
  localparam int SW = $clog2(NS);
  localparam int AW = $clog2(NS * NC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cv = 1'b0;
  logic [3:0] cc = '0;
  logic [SW-1:0] cs = '0;
  logic tk = 1'b0;
  logic eb;

  logic [AW-1:0] cell_addr, eod_mark_addr;
  logic cell_wr_en, cell_rd_en, half_sec_n, active_n, irq_n, mute, pwr_down;
  logic eod_mark_wr, ovf_set, eod_set;

  int tests = 0, fails = 0;
  int tick_div = 1, cyc = 0, eod_at = -1;
  string phase = "R1";

  always #2.5 clk = ~clk;

  sector_sequencer #(.NUM_SECTORS(NS), .CELLS_PER_SECTOR(NC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cv), .cmd_code(cc), .cmd_sector(cs),
    .sample_tick(tk), .eod_bit_in(eb), .cell_addr(cell_addr),
    .cell_wr_en(cell_wr_en), .cell_rd_en(cell_rd_en), .half_sec_n(half_sec_n),
    .active_n(active_n), .irq_n(irq_n), .mute(mute), .pwr_down(pwr_down),
    .eod_mark_wr(eod_mark_wr), .eod_mark_addr(eod_mark_addr),
    .ovf_set(ovf_set), .eod_set(eod_set));

  assign eb = (eod_at >= 0) && (int'(cell_addr) == eod_at);

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tk  <= (tick_div != 0) && (cyc % tick_div == 0);
  end

  // reference state: mode 0 idle, 1 record, 2 play, 3 skip
  int m_mode = 0, m_loop = 0, m_sec = 0, m_cell = 0, m_pd = 0, m_any = 0, m_last = 0;
  int m_pv = 0, m_pc = 0, m_ps = 0, m_mark = 0, m_ovf = 0, m_eod = 0;
  bit e_imm, e_ld, e_go, e_wr, e_rd, e_act;
  int e_addr;

  function automatic int opof(int c);
    return (c + 1) / 2;
  endfunction

  task automatic calc();
    bit eff;
    e_act  = (m_mode != 0);
    eff    = cv && (m_pd != 0 ? cc == 9 : (cc >= 1 && cc <= 8));
    e_imm  = eff && (!e_act || m_cell < HF);
    e_ld   = eff && e_act && m_cell >= HF;
    e_go   = e_act && tk && !e_imm;
    e_wr   = e_go && m_mode == 1;
    e_rd   = e_go && m_mode >= 2;
    e_addr = m_sec * NC + m_cell;
  endtask

  task automatic step_next();
    if (m_sec == NS - 1) begin m_mode = 0; m_ovf = 1; end
    else m_sec++;
  endtask

  always @(posedge clk) begin
    calc();
    m_mark = 0; m_ovf = 0; m_eod = 0;
    if (!rst_n) begin
      m_mode = 0; m_loop = 0; m_sec = 0; m_cell = 0; m_pd = 0; m_any = 0; m_last = 0; m_pv = 0;
    end else if (e_imm) begin
      m_pv = 0;
      if (cc == 9) m_pd = 0;
      else if (cc == 7 || cc == 8) begin
        if (m_mode == 1 && m_any != 0) m_mark = 1;
        m_mode = 0; m_pd = (cc == 8);
      end else begin
        m_mode = opof(cc); m_loop = cc % 2; m_cell = 0; m_any = 0;
        if (m_loop != 0) m_sec = cs;
      end
    end else if (e_go) begin
      if (e_wr) begin m_last = e_addr; m_any = 1; end
      if (e_rd && eb) begin m_mode = 0; m_eod = 1; m_pv = 0; end
      else if (m_cell == NC - 1) begin
        int pv, pc, ps;
        pv = e_ld ? 1 : m_pv; pc = e_ld ? int'(cc) : m_pc; ps = e_ld ? int'(cs) : m_ps;
        m_pv = 0; m_cell = 0;
        if (pv != 0 && (pc == 7 || pc == 8)) begin
          if (m_mode == 1) m_mark = 1;
          m_mode = 0; m_pd = (pc == 8);
        end else if (pv != 0) begin
          m_any = (m_any != 0 && opof(pc) == 1);
          m_mode = opof(pc); m_loop = pc % 2;
          if (m_loop != 0) m_sec = ps; else step_next();
        end else if (m_loop == 0) step_next();
      end else begin
        m_cell++;
        if (e_ld) begin m_pv = 1; m_pc = cc; m_ps = cs; end
      end
    end else if (e_ld) begin
      m_pv = 1; m_pc = cc; m_ps = cs;
    end
  end

  task automatic chk(string tag, string nm, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (scenario %s) %s actual=%0d expected=%0d", tag, phase, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    calc();
    chk("R2", "cell_wr_en", cell_wr_en, e_wr);
    chk("R2", "cell_rd_en", cell_rd_en, e_rd);
    if (e_wr || e_rd) chk("R2", "cell_addr", cell_addr, e_addr);
    chk("R3", "half_sec_n", half_sec_n, !(e_act && m_cell >= HF));
    chk("R10", "active_n", active_n, !e_act);
    chk("R10", "mute", mute, m_mode == 3);
    chk("R11", "pwr_down", pwr_down, m_pd);
    chk("R7", "eod_set", eod_set, m_eod);
    chk("R9", "ovf_set", ovf_set, m_ovf);
    chk("R7", "irq_n", irq_n, !(m_ovf != 0 || m_eod != 0));
    chk("R8", "eod_mark_wr", eod_mark_wr, m_mark);
    if (m_mark != 0) chk("R8", "eod_mark_addr", eod_mark_addr, m_last);
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(int code, int sec);
    cv = 1'b1; cc = 4'(code); cs = SW'(sec);
    @(negedge clk);
    cv = 1'b0; cc = '0;
  endtask

  task automatic wait_half(bit lvl);
    int guard = 0;
    while (half_sec_n != lvl && guard < 100) begin @(negedge clk); guard++; end
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    run(3);
    rst_n = 1'b1;
    run(1);
    phase = "R1";
    chk("R1", "active_n", active_n, 1);
    chk("R1", "half_sec_n", half_sec_n, 1);
    chk("R1", "irq_n", irq_n, 1);
    chk("R1", "pwr_down", pwr_down, 0);
    run(3);
    phase = "R4";
    cmd(1, 1); run(20);
    phase = "R6";
    wait_half(1'b0); cmd(3, 2); run(12);
    phase = "R5";
    wait_half(1'b1); cmd(4, 0); run(30);
    phase = "R7";
    eod_at = 5; cmd(5, 0); run(12);
    eod_at = 13; cmd(6, 0); run(20); eod_at = -1;
    phase = "R8";
    tick_div = 3; cmd(1, 3); run(7); cmd(7, 0); run(3);
    cmd(2, 0); run(4); wait_half(1'b0); cmd(3, 0); cmd(7, 0); run(30);
    tick_div = 0; cmd(1, 0); run(2); cmd(7, 0); run(3);
    phase = "R10";
    tick_div = 1; cmd(6, 1); run(10); cmd(7, 0); run(12);
    phase = "R11";
    cmd(3, 1); run(2); cmd(8, 0); run(4);
    cmd(1, 2); run(5); cmd(0, 0); run(2);
    cmd(9, 0); run(2); cmd(3, 2); run(10);
    wait_half(1'b0); cmd(8, 0); run(12);
    cmd(9, 0); run(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule